// File: doc/BRIEF.md
# Lockable SMRAM-at-Base Register with Size Query

This block holds two small configuration registers of a memory controller's host bridge. The first is an 8-bit base-window register. Boot firmware uses it to find out whether a protected RAM window at a fixed base address exists, and then to seal that window. The firmware writes a probe byte, and the register answers with an "in RAM" code. From that point the only bit software may still set is a lock bit. Once that bit is set, the register drops all write access until reset. While locked, the block raises `lock_active`. A separate address router uses this flag to send non-SMM accesses to the window to a sink that reads all ones, while SMM accesses still see RAM.

The second register is 16 bits wide and reports the extended size of the top protected segment. At reset it holds the probe word 0xFFFF. When firmware writes 0xFFFF into it, the register replaces that value with the configured megabyte count. A parameter states whether the base window exists at all. An input carries the 12-bit megabyte count, so the count can never be above 0x0FFF.

The base register is a three-state machine, and its read value depends only on the state:

| State | Read value | Meaning |
|---|---|---|
| ST_OPEN | 0x00 | The state after reset; every write is examined. |
| ST_QUERIED | 0x01 | The probe has been seen; only bit 1 acts. |
| ST_LOCKED | 0x02 | Sealed; every write is ignored. |

The machine has two transitions, and a reset returns it to ST_OPEN:

| Transition | From | To | Condition |
|---|---|---|---|
| T_PROBE | ST_OPEN | ST_QUERIED | A byte-0 write of 0xFF, with the feature present |
| T_SEAL | ST_QUERIED | ST_LOCKED | A byte-0 write with bit 1 set |

All other cases hold the current state.

Top module: `smram_base_lock`

## Requirements
- R1: After reset the base register reads 0x00 and `lock_active` is 0. The size register reads 0xFFFF if `ext_mb` is nonzero during reset, and 0x0000 if it is zero.
- R2: In ST_OPEN, a base write of 0xFF makes the base register read 0x01 (ST_QUERIED) one cycle later.
- R3: In ST_OPEN, a base write of any value other than 0xFF is discarded and the register keeps reading 0x00. This includes the lock value 0x02.
- R4: In ST_QUERIED, a base write with bit 1 clear leaves the register at 0x01. All bits other than bit 1 have no effect.
- R5: In ST_QUERIED, a base write with bit 1 set moves to ST_LOCKED. The register then reads exactly 0x02 and `lock_active` is 1.
- R6: In ST_LOCKED every base write is ignored and `lock_active` stays 1. Only reset returns the register to ST_OPEN, after which the probe works again.
- R7: With FEATURE_EN = 0 the base register ignores all writes. It reads 0x00 and `lock_active` stays 0.
- R8: A size-register write (`wr_addr` = 1) replaces the byte lanes whose `wr_be` bit is set. Bit 0 selects bits 7:0 and bit 1 selects bits 15:8. If the merged word is 0xFFFF and `ext_mb` is nonzero, the register stores `ext_mb` zero-extended instead.
- R9: When `ext_mb` is zero, a merged word of 0xFFFF is stored unchanged.
- R10: A base write needs `wr_addr` = 0 and `wr_be[0]` = 1, and takes its value from `wr_data[7:0]`. Base writes leave the size register unchanged, and size writes leave the base register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 1 | Register select: 0 is the base register, 1 is the size register |
| wr_be | input | 2 | Byte-lane enables |
| wr_data | input | 16 | Write data |
| ext_mb | input | 12 | Configured extended size in megabytes |
| base_rdata | output | 8 | Base register read value |
| ext_rdata | output | 16 | Size register read value |
| lock_active | output | 1 | High while the window is sealed |

## Verification
Every result is registered, so a write presented before a rising edge shows on the read ports and on `lock_active` right after that edge, one cycle after the stimulus. Reset values appear as soon as reset is asserted. The bench drives each write for exactly one edge and compares the outputs at the following falling edge. This catches both a missing update and a result that arrives a cycle late. A second instance with the feature absent receives the same stimulus and is compared at the same point.

// File: rtl/smbl_pkg.sv
package smbl_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_OPEN    = 2'd0,
        ST_QUERIED = 2'd1,
        ST_LOCKED  = 2'd2
    } base_state_e;

    // Probe byte, "in RAM" answer and lock bit of the base register
    localparam logic [BYTE_W-1:0] PROBE_BYTE = 8'hFF;
    localparam logic [BYTE_W-1:0] IN_RAM_VAL = 8'h01;
    localparam logic [BYTE_W-1:0] LOCK_BIT   = 8'h02;
endpackage

// File: rtl/smbl_write_decode.sv
module smbl_write_decode #(
    parameter int LANES = 2
) (
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [LANES-1:0] wr_be,
    output logic             base_wr,
    output logic             ext_wr
);
    // Base register lives in lane 0 only
    assign base_wr = wr_en && !wr_addr && wr_be[0];
    assign ext_wr  = wr_en &&  wr_addr && (|wr_be);
endmodule

// File: rtl/smbl_base_fsm.sv
module smbl_base_fsm
    import smbl_pkg::*;
#(
    parameter bit FEATURE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [BYTE_W-1:0] base_byte,
    output logic [BYTE_W-1:0] base_rdata,
    output logic              lock_active
);
    base_state_e state_q, state_d;
    logic        wr_ok;

    assign wr_ok = base_wr && FEATURE_EN;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                // T_PROBE; any other value is discarded
                if (wr_ok && base_byte == PROBE_BYTE) state_d = ST_QUERIED;
            end
            ST_QUERIED: begin
                // T_SEAL; only the lock bit is writable
                if (wr_ok && (base_byte & LOCK_BIT) != '0) state_d = ST_LOCKED;
            end
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        base_rdata  = '0;
        lock_active = 1'b0;
        unique case (state_q)
            ST_OPEN:    base_rdata = '0;
            ST_QUERIED: base_rdata = IN_RAM_VAL;
            ST_LOCKED: begin
                base_rdata  = LOCK_BIT;
                lock_active = 1'b1;
            end
            default:    base_rdata = '0;
        endcase
    end
endmodule

// File: rtl/smbl_ext_size.sv
module smbl_ext_size #(
    parameter int LANES  = 2,
    parameter int BYTE_W = 8,
    parameter int MB_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ext_wr,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*BYTE_W-1:0] wr_data,
    input  logic [MB_W-1:0]         ext_mb,
    output logic [LANES*BYTE_W-1:0] ext_rdata
);
    localparam int DATA_W = LANES * BYTE_W;
    localparam logic [DATA_W-1:0] PROBE_WORD = {DATA_W{1'b1}};

    logic [DATA_W-1:0] q, merged, next_val;
    logic              have_size;

    assign have_size = |ext_mb;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*BYTE_W +: BYTE_W] = wr_be[l] ? wr_data[l*BYTE_W +: BYTE_W]
                                                     : q[l*BYTE_W +: BYTE_W];
    end

    always_comb begin
        if (have_size && merged == PROBE_WORD)
            next_val = {{(DATA_W-MB_W){1'b0}}, ext_mb};
        else
            next_val = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= have_size ? PROBE_WORD : '0;
        else if (ext_wr) q <= next_val;
    end

    assign ext_rdata = q;
endmodule

// File: rtl/smram_base_lock.sv
module smram_base_lock
    import smbl_pkg::*;
#(
    parameter bit FEATURE_EN = 1'b1,
    parameter int LANES      = 2,
    parameter int MB_W       = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_addr,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*BYTE_W-1:0] wr_data,
    input  logic [MB_W-1:0]         ext_mb,
    output logic [BYTE_W-1:0]       base_rdata,
    output logic [LANES*BYTE_W-1:0] ext_rdata,
    output logic                    lock_active
);
    logic base_wr, ext_wr;

    smbl_write_decode #(.LANES(LANES)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .base_wr (base_wr),
        .ext_wr  (ext_wr)
    );

    smbl_base_fsm #(.FEATURE_EN(FEATURE_EN)) u_base (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_wr     (base_wr),
        .base_byte   (wr_data[BYTE_W-1:0]),
        .base_rdata  (base_rdata),
        .lock_active (lock_active)
    );

    smbl_ext_size #(.LANES(LANES), .BYTE_W(BYTE_W), .MB_W(MB_W)) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_wr    (ext_wr),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .ext_mb    (ext_mb),
        .ext_rdata (ext_rdata)
    );
endmodule

// File: rtl/smram_base_lock_chk.sv
module smram_base_lock_chk #(
    parameter bit FEATURE_EN = 1'b1,
    parameter int LANES      = 2,
    parameter int MB_W       = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                wr_addr,
    input logic [LANES-1:0]    wr_be,
    input logic [LANES*8-1:0]  wr_data,
    input logic [MB_W-1:0]     ext_mb,
    input logic [7:0]          base_rdata,
    input logic [LANES*8-1:0]  ext_rdata,
    input logic                lock_active
);
    logic bw, ew;
    assign bw = wr_en && !wr_addr && wr_be[0];
    assign ew = wr_en &&  wr_addr && (|wr_be);

    assert_probe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (FEATURE_EN && bw && base_rdata == 8'h00 && wr_data[7:0] == 8'hFF)
        |=> base_rdata == 8'h01);

    assert_discard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bw && base_rdata == 8'h00 && wr_data[7:0] != 8'hFF)
        |=> base_rdata == 8'h00);

    assert_queried_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (base_rdata == 8'h01 && !(bw && wr_data[1])) |=> base_rdata == 8'h01);

    assert_lock_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |-> base_rdata == 8'h02);

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |=> lock_active);

    assert_absent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !FEATURE_EN |-> (base_rdata == 8'h00 && !lock_active));

    assert_ext_query_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ew && wr_be == '1 && wr_data == '1 && ext_mb != '0)
        |=> ext_rdata == {{(LANES*8-MB_W){1'b0}}, $past(ext_mb)});

    assert_ext_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ew |=> $stable(ext_rdata));
endmodule

bind smram_base_lock smram_base_lock_chk #(
    .FEATURE_EN(FEATURE_EN), .LANES(LANES), .MB_W(MB_W)
) u_chk (.*);

// File: tb/smram_base_lock_tb.sv
module smram_base_lock_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    typedef struct packed {
        logic        addr;
        logic [1:0]  be;
        logic [15:0] data;
        logic [7:0]  eb;
        logic [15:0] ee;
        logic        el;
        logic [3:0]  req;
    } vec_t;

    // ext_mb = 0x010 for the table walk
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b01, 16'h0002, 8'h00, 16'hFFFF, 1'b0, 4'd3},
        '{1'b0, 2'b01, 16'h0055, 8'h00, 16'hFFFF, 1'b0, 4'd3},
        '{1'b0, 2'b10, 16'h00FF, 8'h00, 16'hFFFF, 1'b0, 4'd10},
        '{1'b1, 2'b11, 16'h1234, 8'h00, 16'h1234, 1'b0, 4'd8},
        '{1'b1, 2'b01, 16'h00FF, 8'h00, 16'h12FF, 1'b0, 4'd8},
        '{1'b1, 2'b10, 16'hFF00, 8'h00, 16'h0010, 1'b0, 4'd8},
        '{1'b1, 2'b11, 16'hFFFF, 8'h00, 16'h0010, 1'b0, 4'd8},
        '{1'b0, 2'b01, 16'hABFF, 8'h01, 16'h0010, 1'b0, 4'd2},
        '{1'b0, 2'b01, 16'h00FD, 8'h01, 16'h0010, 1'b0, 4'd4},
        '{1'b0, 2'b01, 16'h0001, 8'h01, 16'h0010, 1'b0, 4'd4},
        '{1'b0, 2'b01, 16'h0003, 8'h02, 16'h0010, 1'b1, 4'd5},
        '{1'b0, 2'b01, 16'h00FF, 8'h02, 16'h0010, 1'b1, 4'd6},
        '{1'b0, 2'b01, 16'h0000, 8'h02, 16'h0010, 1'b1, 4'd6},
        '{1'b1, 2'b11, 16'hABCD, 8'h02, 16'hABCD, 1'b1, 4'd10},
        '{1'b0, 2'b11, 16'h5501, 8'h02, 16'hABCD, 1'b1, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [1:0]  wr_be = '0;
    logic [15:0] wr_data = '0;
    logic [11:0] ext_mb = 12'h010;
    logic [7:0]  base_rdata, nf_base;
    logic [15:0] ext_rdata, nf_ext;
    logic        lock_active, nf_lock;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smram_base_lock u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .ext_mb(ext_mb),
        .base_rdata(base_rdata), .ext_rdata(ext_rdata), .lock_active(lock_active)
    );

    smram_base_lock #(.FEATURE_EN(1'b0)) u_nf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .ext_mb(ext_mb),
        .base_rdata(nf_base), .ext_rdata(nf_ext), .lock_active(nf_lock)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // One write, captured at the next rising edge; sample at the falling edge after it
    task automatic do_write(input logic a, input logic [1:0] be, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++; checks++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        #(CLK_PERIOD/4);
        // R1 reset values while reset is held
        chk("R1 base in reset", {24'd0, base_rdata}, 32'h00);
        do_reset();
        chk("R1 base", {24'd0, base_rdata}, 32'h00);
        chk("R1 lock", {31'd0, lock_active}, 32'd0);
        chk("R1 ext nonzero count", {16'd0, ext_rdata}, 32'hFFFF);

        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].addr, VECS[i].be, VECS[i].data);
            chk($sformatf("R%0d vec %0d base", VECS[i].req, i), {24'd0, base_rdata}, {24'd0, VECS[i].eb});
            chk($sformatf("R%0d vec %0d ext", VECS[i].req, i), {16'd0, ext_rdata}, {16'd0, VECS[i].ee});
            chk($sformatf("R%0d vec %0d lock", VECS[i].req, i), {31'd0, lock_active}, {31'd0, VECS[i].el});
            // R7: absent feature never moves
            chk($sformatf("R7 vec %0d base", i), {24'd0, nf_base}, 32'h00);
            chk($sformatf("R7 vec %0d lock", i), {31'd0, nf_lock}, 32'd0);
            chk($sformatf("R8 vec %0d absent ext", i), {16'd0, nf_ext}, {16'd0, VECS[i].ee});
        end

        // R6: reset unlocks, probe works again
        do_reset();
        chk("R6 base after reset", {24'd0, base_rdata}, 32'h00);
        chk("R6 lock after reset", {31'd0, lock_active}, 32'd0);
        do_write(1'b0, 2'b01, 16'h00FF);
        chk("R2 probe after reset", {24'd0, base_rdata}, 32'h01);
        do_write(1'b0, 2'b01, 16'h00FF);
        chk("R5 seal with 0xFF", {24'd0, base_rdata}, 32'h02);
        chk("R5 lock flag", {31'd0, lock_active}, 32'd1);

        // R9: zero count leaves probe word alone
        ext_mb = 12'h000;
        do_reset();
        chk("R1 ext zero count", {16'd0, ext_rdata}, 32'h0000);
        do_write(1'b1, 2'b11, 16'hFFFF);
        chk("R9 probe word kept", {16'd0, ext_rdata}, 32'hFFFF);

        // R8: maximum 12-bit count
        ext_mb = 12'hFFF;
        do_reset();
        chk("R1 ext max count", {16'd0, ext_rdata}, 32'hFFFF);
        do_write(1'b1, 2'b11, 16'hFFFF);
        chk("R8 max count answer", {16'd0, ext_rdata}, 32'h0FFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule